// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block receives configuration words over a three-wire serial port made of a serial clock, a data line and a load strobe. All three wires are sampled in the system clock domain through two-flop synchronizers, and edges are detected after synchronization. On each detected rising edge of the serial clock, one data bit enters a 23-bit shift register. The bits arrive most significant first.

When a rising edge of the load strobe is detected, the two bits that arrived last select one of four destination latches. These are the IF reference divider, the IF programmable divider, the RF reference divider and the RF programmable divider. Only that latch takes the payload. In the next cycle the block raises a one-cycle update pulse for that destination.

Reference destinations hold a 14-bit divide value, a charge-pump current select bit and a status-output select bit. The status-output bit chooses between the lock indication and the phase comparator monitor. Programmable destinations hold a 7-bit swallow value, an 11-bit main count and a prescaler-select bit. A divide value or main count below 3 is still stored, and a sticky invalid flag marks it until the next load of that destination.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, every latched field, every invalid flag and every update pulse is 0.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into bit 0 of a 23-bit register. Earlier bits move toward bit 22, so a word is sent most significant bit first.
- R3: At a load, bits [1:0] select the destination. 00 selects IF reference, 01 IF programmable, 10 RF reference and 11 RF programmable.
- R4: A reference load stores bits [15:2] as the divide value, bit 16 as the charge-pump high-current select and bit 17 as the status-output monitor select. Bits [22:18] are ignored.
- R5: A programmable load stores bits [8:2] as the swallow value, bits [19:9] as the main count and bit 20 as the prescaler select. Bits [22:21] are ignored.
- R6: A load changes only the selected destination. All other latches and flags keep their values.
- R7: The update bus has one bit per destination, indexed by the select code. The selected bit is high for exactly one clock per load strobe rising edge, and at most one bit is high at any time.
- R8: A reference load with a divide value below 3 stores the value and sets that destination's invalid flag. A load of 3 or more clears the flag.
- R9: A programmable load with a main count below 3 stores the value and sets that destination's invalid flag. A count of 3 or more clears the flag.
- R10: Shifting bits without a rising load strobe changes no latch, no flag and no update bit.
- R11: When more than 23 bits are shifted before a load, only the last 23 take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Load strobe (asynchronous) |
| if_ref_div | output | 14 | IF reference divide value |
| if_ref_cp_hi | output | 1 | IF charge-pump high-current select |
| if_ref_mon_sel | output | 1 | IF status output carries the comparator monitor |
| if_ref_bad | output | 1 | IF reference divide value below minimum |
| if_prg_swal | output | 7 | IF swallow value |
| if_prg_cnt | output | 11 | IF main count |
| if_prg_psel | output | 1 | IF prescaler select |
| if_prg_bad | output | 1 | IF main count below minimum |
| rf_ref_div | output | 14 | RF reference divide value |
| rf_ref_cp_hi | output | 1 | RF charge-pump high-current select |
| rf_ref_mon_sel | output | 1 | RF status output carries the comparator monitor |
| rf_ref_bad | output | 1 | RF reference divide value below minimum |
| rf_prg_swal | output | 7 | RF swallow value |
| rf_prg_cnt | output | 11 | RF main count |
| rf_prg_psel | output | 1 | RF prescaler select |
| rf_prg_bad | output | 1 | RF main count below minimum |
| upd | output | 4 | One-cycle update pulse per destination, indexed by select code |

## Verification
A wrong shift register state shows up as a misplaced or shifted field in whichever destination the next load selects. A bit-order or shift-count fault therefore appears at the outputs as soon as the first word is loaded. A decode fault shows the payload in the wrong latch, a pulse on the wrong update bit, or a neighbouring latch that changes although it was not selected. All of these are visible within a few clocks of the load strobe's rising edge. Invalid flags are checked across a sweep of small divide values, so an off-by-one in the minimum comparison appears exactly at the values 2 and 3.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SR_W     = 23;
  localparam int CTRL_W   = 2;
  localparam int REF_W    = 14;
  localparam int SWL_W    = 7;
  localparam int CNT_W    = 11;
  localparam int MIN_DIV  = 3;
  localparam int N_DST    = 4;
  // derived field positions
  localparam int REF_LO   = CTRL_W;
  localparam int REF_CP   = REF_LO + REF_W;
  localparam int REF_MON  = REF_CP + 1;
  localparam int SWL_LO   = CTRL_W;
  localparam int CNT_LO   = SWL_LO + SWL_W;
  localparam int PSEL_POS = CNT_LO + CNT_W;

  typedef struct packed {
    logic [REF_W-1:0] div;
    logic             cp_hi;
    logic             mon_sel;
  } ref_cfg_t;

  typedef struct packed {
    logic [SWL_W-1:0] swal;
    logic [CNT_W-1:0] cnt;
    logic             psel;
  } prg_cfg_t;
endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;

  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (shift_en) q_d = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])));
  p_shift_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/scl_ref_latch.sv
module scl_ref_latch
  import scl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [SR_W-1:0] word,
  output ref_cfg_t        cfg,
  output logic            bad,
  output logic            upd
);
  ref_cfg_t cfg_d;
  logic     bad_d;

  always_comb begin
    cfg_d = cfg;
    bad_d = bad;
    if (ld) begin
      cfg_d.div     = word[REF_LO +: REF_W];
      cfg_d.cp_hi   = word[REF_CP];
      cfg_d.mon_sel = word[REF_MON];
      bad_d         = (word[REF_LO +: REF_W] < REF_W'(MIN_DIV));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      bad <= 1'b0;
      upd <= 1'b0;
    end else begin
      cfg <= cfg_d;
      bad <= bad_d;
      upd <= ld;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(cfg) && $stable(bad));
  p_load_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cfg.div == $past(word[REF_LO +: REF_W]));
  p_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> cfg.div < REF_W'(MIN_DIV));
endmodule

// File: rtl/scl_prg_latch.sv
module scl_prg_latch
  import scl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [SR_W-1:0] word,
  output prg_cfg_t        cfg,
  output logic            bad,
  output logic            upd
);
  prg_cfg_t cfg_d;
  logic     bad_d;

  always_comb begin
    cfg_d = cfg;
    bad_d = bad;
    if (ld) begin
      cfg_d.swal = word[SWL_LO +: SWL_W];
      cfg_d.cnt  = word[CNT_LO +: CNT_W];
      cfg_d.psel = word[PSEL_POS];
      bad_d      = (word[CNT_LO +: CNT_W] < CNT_W'(MIN_DIV));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      bad <= 1'b0;
      upd <= 1'b0;
    end else begin
      cfg <= cfg_d;
      bad <= bad_d;
      upd <= ld;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(cfg) && $stable(bad));
  p_load_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cfg.cnt == $past(word[CNT_LO +: CNT_W]));
  p_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> cfg.cnt < CNT_W'(MIN_DIV));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [REF_W-1:0]  if_ref_div,
  output logic              if_ref_cp_hi,
  output logic              if_ref_mon_sel,
  output logic              if_ref_bad,
  output logic [SWL_W-1:0]  if_prg_swal,
  output logic [CNT_W-1:0]  if_prg_cnt,
  output logic              if_prg_psel,
  output logic              if_prg_bad,
  output logic [REF_W-1:0]  rf_ref_div,
  output logic              rf_ref_cp_hi,
  output logic              rf_ref_mon_sel,
  output logic              rf_ref_bad,
  output logic [SWL_W-1:0]  rf_prg_swal,
  output logic [CNT_W-1:0]  rf_prg_cnt,
  output logic              rf_prg_psel,
  output logic              rf_prg_bad,
  output logic [N_DST-1:0]  upd
);
  localparam int N_CH = N_DST / 2;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic sclk_lvl, sclk_rise, dat_lvl, dat_rise, le_lvl, le_rise;

  scl_sync_edge #(.STAGES(2)) u_sync_clk (
    .clk(clk), .rst_n(rst_ni), .din(ser_clk), .lvl(sclk_lvl), .rise(sclk_rise));
  scl_sync_edge #(.STAGES(2)) u_sync_dat (
    .clk(clk), .rst_n(rst_ni), .din(ser_dat), .lvl(dat_lvl), .rise(dat_rise));
  scl_sync_edge #(.STAGES(2)) u_sync_le (
    .clk(clk), .rst_n(rst_ni), .din(ser_le), .lvl(le_lvl), .rise(le_rise));

  logic [SR_W-1:0] sr_q;
  scl_shreg #(.W(SR_W)) u_shreg (
    .clk(clk), .rst_n(rst_ni), .shift_en(sclk_rise), .din(dat_lvl), .q(sr_q));

  ref_cfg_t          ref_cfg [N_CH];
  prg_cfg_t          prg_cfg [N_CH];
  logic [N_CH-1:0]   ref_bad, prg_bad, ref_upd, prg_upd, ref_ld, prg_ld;
  logic [CTRL_W-1:0] sel;

  assign sel = sr_q[CTRL_W-1:0];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign ref_ld[ch] = le_rise && (sel == {1'(ch), 1'b0});
    assign prg_ld[ch] = le_rise && (sel == {1'(ch), 1'b1});

    scl_ref_latch u_ref (
      .clk(clk), .rst_n(rst_ni), .ld(ref_ld[ch]), .word(sr_q),
      .cfg(ref_cfg[ch]), .bad(ref_bad[ch]), .upd(ref_upd[ch]));
    scl_prg_latch u_prg (
      .clk(clk), .rst_n(rst_ni), .ld(prg_ld[ch]), .word(sr_q),
      .cfg(prg_cfg[ch]), .bad(prg_bad[ch]), .upd(prg_upd[ch]));

    assign upd[2*ch]   = ref_upd[ch];
    assign upd[2*ch+1] = prg_upd[ch];
  end

  assign if_ref_div     = ref_cfg[0].div;
  assign if_ref_cp_hi   = ref_cfg[0].cp_hi;
  assign if_ref_mon_sel = ref_cfg[0].mon_sel;
  assign if_ref_bad     = ref_bad[0];
  assign if_prg_swal    = prg_cfg[0].swal;
  assign if_prg_cnt     = prg_cfg[0].cnt;
  assign if_prg_psel    = prg_cfg[0].psel;
  assign if_prg_bad     = prg_bad[0];
  assign rf_ref_div     = ref_cfg[1].div;
  assign rf_ref_cp_hi   = ref_cfg[1].cp_hi;
  assign rf_ref_mon_sel = ref_cfg[1].mon_sel;
  assign rf_ref_bad     = ref_bad[1];
  assign rf_prg_swal    = prg_cfg[1].swal;
  assign rf_prg_cnt     = prg_cfg[1].cnt;
  assign rf_prg_psel    = prg_cfg[1].psel;
  assign rf_prg_bad     = prg_bad[1];

  p_upd_onehot_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(upd));
  p_upd_follows_le_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (upd != '0) |-> $past(le_rise));
  p_no_le_no_upd_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !le_rise |=> (upd == '0));
endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [13:0] if_ref_div, rf_ref_div;
  logic if_ref_cp_hi, if_ref_mon_sel, if_ref_bad, rf_ref_cp_hi, rf_ref_mon_sel, rf_ref_bad;
  logic [6:0] if_prg_swal, rf_prg_swal;
  logic [10:0] if_prg_cnt, rf_prg_cnt;
  logic if_prg_psel, if_prg_bad, rf_prg_psel, rf_prg_bad;
  logic [3:0] upd;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  serial_cfg_loader u_dut (.*);

  // expected model, index 0 = IF, 1 = RF
  int e_div[2], e_cp[2], e_mon[2], e_rbad[2];
  int e_swal[2], e_cnt[2], e_psel[2], e_pbad[2];
  int pulses[4];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " if div"},  if_ref_div,     e_div[0]);
    chk({req, " if cp"},   if_ref_cp_hi,   e_cp[0]);
    chk({req, " if mon"},  if_ref_mon_sel, e_mon[0]);
    chk({req, " if rbad"}, if_ref_bad,     e_rbad[0]);
    chk({req, " if swal"}, if_prg_swal,    e_swal[0]);
    chk({req, " if cnt"},  if_prg_cnt,     e_cnt[0]);
    chk({req, " if psel"}, if_prg_psel,    e_psel[0]);
    chk({req, " if pbad"}, if_prg_bad,     e_pbad[0]);
    chk({req, " rf div"},  rf_ref_div,     e_div[1]);
    chk({req, " rf cp"},   rf_ref_cp_hi,   e_cp[1]);
    chk({req, " rf mon"},  rf_ref_mon_sel, e_mon[1]);
    chk({req, " rf rbad"}, rf_ref_bad,     e_rbad[1]);
    chk({req, " rf swal"}, rf_prg_swal,    e_swal[1]);
    chk({req, " rf cnt"},  rf_prg_cnt,     e_cnt[1]);
    chk({req, " rf psel"}, rf_prg_psel,    e_psel[1]);
    chk({req, " rf pbad"}, rf_prg_bad,     e_pbad[1]);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [22:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
      wait_clk(3);
    end
  endtask

  // raise the strobe, count update pulses, then drop it
  task automatic strobe(int exp_dst, string req);
    for (int k = 0; k < 4; k++) pulses[k] = 0;
    ser_le = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (upd[k]) pulses[k]++;
    end
    ser_le = 1'b0;
    wait_clk(4);
    for (int k = 0; k < 4; k++) if (upd[k]) pulses[k]++;
    for (int k = 0; k < 4; k++)
      chk({req, " R7 upd pulse count"}, pulses[k], (k == exp_dst) ? 1 : 0);
  endtask

  function automatic logic [22:0] ref_word(int ch, int div, int cp, int mon, int junk);
    return {5'(junk), 1'(mon), 1'(cp), 14'(div), 1'(ch), 1'b0};
  endfunction

  function automatic logic [22:0] prg_word(int ch, int swal, int cnt, int psel, int junk);
    return {2'(junk), 1'(psel), 11'(cnt), 7'(swal), 1'(ch), 1'b1};
  endfunction

  task automatic load_ref(int ch, int div, int cp, int mon, int junk);
    send_bits(ref_word(ch, div, cp, mon, junk), 23);
    strobe(2 * ch, "R3");
    e_div[ch] = div; e_cp[ch] = cp; e_mon[ch] = mon;
    e_rbad[ch] = (div < 3) ? 1 : 0;
    check_all("R4 R6 R8");
  endtask

  task automatic load_prg(int ch, int swal, int cnt, int psel, int junk);
    send_bits(prg_word(ch, swal, cnt, psel, junk), 23);
    strobe(2 * ch + 1, "R3");
    e_swal[ch] = swal; e_cnt[ch] = cnt; e_psel[ch] = psel;
    e_pbad[ch] = (cnt < 3) ? 1 : 0;
    check_all("R5 R6 R9");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      e_div[c] = 0; e_cp[c] = 0; e_mon[c] = 0; e_rbad[c] = 0;
      e_swal[c] = 0; e_cnt[c] = 0; e_psel[c] = 0; e_pbad[c] = 0;
    end
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R1");
    chk("R1 upd", upd, 0);

    // divide value sweep on both reference latches, minimum boundary included
    for (int ch = 0; ch < 2; ch++)
      for (int d = 0; d < 40; d++)
        load_ref(ch, (ch == 0) ? d : 16383 - d + ((d < 4) ? 0 : 0), d % 2, (d / 2) % 2, d);
    // small values on RF reference to hit the bad flag there too
    for (int d = 0; d < 5; d++) load_ref(1, d, 1, 0, 31 - d);
    load_ref(0, 16383, 1, 1, 31);
    load_ref(0, 8192, 0, 1, 0);

    // main count sweep with varied swallow values
    for (int ch = 0; ch < 2; ch++)
      for (int n = 0; n < 24; n++)
        load_prg(ch, (n * 37 + ch) % 128, (n < 12) ? n : 2047 - n * 41, n % 2, n);
    load_prg(0, 127, 2047, 1, 3);
    load_prg(1, 0, 3, 0, 0);

    // R10: shifting without a strobe changes nothing
    for (int k = 0; k < 4; k++) pulses[k] = 0;
    send_bits(ref_word(0, 5, 1, 1, 0), 23);
    check_all("R10 no strobe");
    chk("R10 upd idle", upd, 0);

    // R11: extra leading bits are shifted out
    send_bits(23'h7FFFFF, 9);
    load_prg(1, 85, 1234, 1, 1);
    send_bits(23'h555555, 17);
    load_ref(1, 777, 0, 1, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule